// File: doc/BRIEF.md
# Audio Stream Sample Counter with Compare Interrupt

This block holds the control state of an audio streaming interface. A host reads and writes four registers over a simple word-addressed bus: control, volume, sample count and compare. While the sample-clock enable bit in the control register is set, each pulse on the sample tick input adds one to the sample counter. The volume register is plain storage that a downstream mixer can use.

The increment that takes the counter onto the compare value is a match. A match sets the interrupt status bit unless the match-ignore bit is set. The interrupt output is raised while both the status bit and the mask bit are set. The host clears the status bit by writing 1 to it. Writing 1 to the counter-clear bit sets the counter to zero.

Two rate-select outputs go to an external clock generator. Each comes from its own control bit, and the two bits use opposite encodings. Sample data and clock synthesis are handled outside this block.

Top module: `aud_stream_ctl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and both rate-select outputs are 0.
- R2: The counter (address 2) increases by one on each clock edge where `sampleTick` is 1 and control bit 0 (clock enable) is 1. In every other cycle it holds its value, unless it is cleared.
- R3: `streamRateSel` follows control bit 1 (0 = 32000, 1 = 48000). `dmaRateSel` follows control bit 6 (0 = 48000, 1 = 32000). Each output changes only with its own bit.
- R4: With control bit 4 at 0, an increment that takes the counter to the value in the compare register (address 3) sets status bit 3 on the same edge as the increment.
- R5: With control bit 4 at 1, a match leaves status bit 3 unchanged.
- R6: A control write with bit 3 at 1 clears the status bit, and a write with bit 3 at 0 leaves it as it was. If a match that sets the status happens on the same edge as the clearing write, the status bit stays 1.
- R7: A control write with bit 5 at 1 sets the counter to 0 on that edge. This takes priority over a sample tick on the same edge, and the clear is never a match. Bit 5 always reads back 0.
- R8: `irq` is 1 exactly when status bit 3 and mask bit 2 are both 1.
- R9: The volume (address 1) and compare (address 3) registers read back the value last written, truncated to their width and zero-extended. Writes to the counter address are ignored.
- R10: After all ones, the counter wraps to 0. If the compare value is 0, this wrap counts as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 2 | Register select: 0 control, 1 volume, 2 counter, 3 compare |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Combinational read data for `hostAddr` |
| sampleTick | input | 1 | One-cycle pulse per sample period |
| streamRateSel | output | 1 | Streaming path rate select |
| dmaRateSel | output | 1 | DMA path rate select |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit counter and a 16-bit volume register. At that width a single directed run of 256 ticks covers the wrap onto a compare value of 0. Random compare values then land on the counter often enough to produce many matches, so matches coincide with status-clear writes, counter clears and enable changes. Using 16 bits for volume exercises truncation and zero-extension on readback.

// File: rtl/aud_sc_pkg.sv
package aud_sc_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  // control register bit positions
  localparam int BIT_EN     = 0;
  localparam int BIT_RATE   = 1;
  localparam int BIT_MASK   = 2;
  localparam int BIT_STAT   = 3;
  localparam int BIT_IGNORE = 4;
  localparam int BIT_CLEAR  = 5;
  localparam int BIT_DMA    = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_VOL  = 2'd1,
    REG_CNT  = 2'd2,
    REG_CMP  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic volWr;
    logic cmpWr;
  } dpStrobe_t;

endpackage

// File: rtl/aud_sc_ctrl.sv
module aud_sc_ctrl
  import aud_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              sampleTick,
  input  logic              matchHit,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlRead,
  output logic              irq,
  output logic              streamRateSel,
  output logic              dmaRateSel
);

  logic clkEn;
  logic rateSel;
  logic intMask;
  logic intStatus;
  logic matchIgnore;
  logic dmaRate;

  logic ctrlWr;
  logic setStatus;
  logic clrStatus;

  always_comb begin
    ctrlWr          = hostWe && (hostAddr == REG_CTRL);
    strobe.cntClear = ctrlWr && hostWdata[BIT_CLEAR];
    strobe.cntStep  = sampleTick && clkEn && !strobe.cntClear;
    strobe.volWr    = hostWe && (hostAddr == REG_VOL);
    strobe.cmpWr    = hostWe && (hostAddr == REG_CMP);
    setStatus       = strobe.cntStep && matchHit && !matchIgnore;
    clrStatus       = ctrlWr && hostWdata[BIT_STAT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEn       <= 1'b0;
      rateSel     <= 1'b0;
      intMask     <= 1'b0;
      matchIgnore <= 1'b0;
      dmaRate     <= 1'b0;
    end else if (ctrlWr) begin
      clkEn       <= hostWdata[BIT_EN];
      rateSel     <= hostWdata[BIT_RATE];
      intMask     <= hostWdata[BIT_MASK];
      matchIgnore <= hostWdata[BIT_IGNORE];
      dmaRate     <= hostWdata[BIT_DMA];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          intStatus <= 1'b0;
    else if (setStatus) intStatus <= 1'b1;
    else if (clrStatus) intStatus <= 1'b0;
  end

  always_comb begin
    ctrlRead             = '0;
    ctrlRead[BIT_EN]     = clkEn;
    ctrlRead[BIT_RATE]   = rateSel;
    ctrlRead[BIT_MASK]   = intMask;
    ctrlRead[BIT_STAT]   = intStatus;
    ctrlRead[BIT_IGNORE] = matchIgnore;
    ctrlRead[BIT_DMA]    = dmaRate;
  end

  assign irq           = intStatus & intMask;
  assign streamRateSel = rateSel;
  assign dmaRateSel    = dmaRate;

  // R4: an unignored match sets the status on the next edge
  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && clkEn && !strobe.cntClear && matchHit && !matchIgnore) |=> intStatus);

  // R5: status can only rise from a match seen with ignore off
  assert_ignore_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus) |-> $past(!matchIgnore && matchHit && sampleTick));

  // R6: a clearing write without a concurrent match drops the status
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && hostWdata[BIT_STAT] && !(strobe.cntStep && matchHit && !matchIgnore))
      |=> !intStatus);

  // R3: rate outputs move only on a control write
  assert_rate_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> ($stable(streamRateSel) && $stable(dmaRateSel)));

endmodule

// File: rtl/aud_sc_dp.sv
module aud_sc_dp
  import aud_sc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VOL_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] ctrlRead,
  output logic              matchHit,
  output logic [DATA_W-1:0] hostRdata
);

  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int VOL_PAD = DATA_W - VOL_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] cmpReg;
  logic [VOL_W-1:0] volReg;

  assign countNext = count + 1'b1;
  assign matchHit  = (countNext == cmpReg);

  always_ff @(posedge clk) begin
    if (!rstN)                count <= '0;
    else if (strobe.cntClear) count <= '0;
    else if (strobe.cntStep)  count <= countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cmpReg <= '0;
    else if (strobe.cmpWr) cmpReg <= hostWdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             volReg <= '0;
    else if (strobe.volWr) volReg <= hostWdata[VOL_W-1:0];
  end

  logic [DATA_W-1:0] cntWide;
  logic [DATA_W-1:0] cmpWide;
  logic [DATA_W-1:0] volWide;

  generate
    if (CNT_PAD > 0) begin : g_cntPad
      assign cntWide = {{CNT_PAD{1'b0}}, count};
      assign cmpWide = {{CNT_PAD{1'b0}}, cmpReg};
    end else begin : g_cntFull
      assign cntWide = count;
      assign cmpWide = cmpReg;
    end
    if (VOL_PAD > 0) begin : g_volPad
      assign volWide = {{VOL_PAD{1'b0}}, volReg};
    end else begin : g_volFull
      assign volWide = volReg;
    end
  endgenerate

  always_comb begin
    unique case (hostAddr)
      REG_CTRL: hostRdata = ctrlRead;
      REG_VOL:  hostRdata = volWide;
      REG_CNT:  hostRdata = cntWide;
      default:  hostRdata = cmpWide;
    endcase
  end

  // R2: a step adds exactly one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntStep && !strobe.cntClear) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R2: no step and no clear leaves the counter alone
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntStep && !strobe.cntClear) |=> $stable(count));

  // R7: clear lands on zero
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (count == '0));

  // R9: compare captures the written value
  assert_cmp_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpWr |=> (cmpReg == $past(hostWdata[CNT_W-1:0])));

endmodule

// File: rtl/aud_stream_ctl.sv
module aud_stream_ctl
  import aud_sc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VOL_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  input  logic        sampleTick,
  output logic        streamRateSel,
  output logic        dmaRateSel,
  output logic        irq
);

  dpStrobe_t         strobe;
  logic              matchHit;
  logic [DATA_W-1:0] ctrlRead;

  aud_sc_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hostWe        (hostWe),
    .hostAddr      (hostAddr),
    .hostWdata     (hostWdata),
    .sampleTick    (sampleTick),
    .matchHit      (matchHit),
    .strobe        (strobe),
    .ctrlRead      (ctrlRead),
    .irq           (irq),
    .streamRateSel (streamRateSel),
    .dmaRateSel    (dmaRateSel)
  );

  aud_sc_dp #(
    .CNT_W (CNT_W),
    .VOL_W (VOL_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .ctrlRead  (ctrlRead),
    .matchHit  (matchHit),
    .hostRdata (hostRdata)
  );

  // R8: interrupt only with both status and mask visible in control
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlRead[BIT_STAT] && ctrlRead[BIT_MASK]));

  // R7: the clear bit never reads back set
  assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRead[BIT_CLEAR]);

endmodule

// File: tb/test_aud_stream_ctl.sv
module test_aud_stream_ctl;

  localparam int CW = 8;
  localparam int VW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        sampleTick = 1'b0;
  logic        streamRateSel;
  logic        dmaRateSel;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [CW-1:0] mCnt = '0;
  logic [CW-1:0] mCmp = '0;
  logic [VW-1:0] mVol = '0;
  logic mEn = 0, mRate = 0, mMask = 0, mStat = 0, mIgn = 0, mDma = 0;

  always #5 clk = ~clk;

  aud_stream_ctl #(.CNT_W(CW), .VOL_W(VW)) i_aud_stream_ctl (
    .clk (clk), .rstN (rstN), .hostWe (hostWe), .hostAddr (hostAddr),
    .hostWdata (hostWdata), .hostRdata (hostRdata), .sampleTick (sampleTick),
    .streamRateSel (streamRateSel), .dmaRateSel (dmaRateSel), .irq (irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expCtrl();
    return {25'd0, mDma, 1'b0, mIgn, mStat, mMask, mRate, mEn};
  endfunction

  function automatic logic [31:0] readReg(logic [1:0] a);
    case (a)
      2'd0:    return expCtrl();
      2'd1:    return {{(32-VW){1'b0}}, mVol};
      2'd2:    return {{(32-CW){1'b0}}, mCnt};
      default: return {{(32-CW){1'b0}}, mCmp};
    endcase
  endfunction

  // called just after a posedge: outputs then every register
  task automatic checkAll();
    check("R8 irq", {31'd0, irq}, {31'd0, mStat & mMask});
    check("R3 streamRateSel", {31'd0, streamRateSel}, {31'd0, mRate});
    check("R3 dmaRateSel", {31'd0, dmaRateSel}, {31'd0, mDma});
    for (int a = 0; a < 4; a++) begin
      hostAddr = 2'(a);
      #0.5;
      case (a)
        0:       check("R6 control readback", hostRdata, readReg(2'(a)));
        1:       check("R9 volume readback", hostRdata, readReg(2'(a)));
        2:       check("R2 counter readback", hostRdata, readReg(2'(a)));
        default: check("R9 compare readback", hostRdata, readReg(2'(a)));
      endcase
    end
  endtask

  task automatic step(bit we, logic [1:0] a, logic [31:0] d, bit tk);
    bit ctrlW, clr, stp, hit;
    logic [CW-1:0] nxt;
    @(negedge clk);
    hostWe = we; hostAddr = a; hostWdata = d; sampleTick = tk;
    ctrlW = we && (a == 2'd0);
    clr   = ctrlW && d[5];
    stp   = tk && mEn && !clr;
    nxt   = mCnt + 1'b1;
    hit   = stp && (nxt == mCmp) && !mIgn;
    @(posedge clk);
    #1;
    hostWe = 1'b0; sampleTick = 1'b0;
    if (clr) mCnt = '0; else if (stp) mCnt = nxt;
    if (hit) mStat = 1'b1; else if (ctrlW && d[3]) mStat = 1'b0;
    if (ctrlW) begin
      mEn = d[0]; mRate = d[1]; mMask = d[2]; mIgn = d[4]; mDma = d[6];
    end
    if (we && a == 2'd1) mVol = d[VW-1:0];
    if (we && a == 2'd3) mCmp = d[CW-1:0];
    checkAll();
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] v);
    hostAddr = a;
    #0.5;
    v = hostRdata;
  endtask

  initial begin
    #5_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    checkAll();
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: tick with enable off
    step(0, 2'd0, 0, 1);
    peek(2'd2, v); check("R2 hold when disabled", v, 32'd0);

    // R4 / R8: match sets status, masked in
    step(1, 2'd0, 32'h05, 0);
    step(1, 2'd3, 32'h03, 0);
    repeat (3) step(0, 2'd0, 0, 1);
    peek(2'd0, v); check("R4 status after match", {31'd0, v[3]}, 32'd1);
    check("R8 irq with mask", {31'd0, irq}, 32'd1);

    // R6: write-1 clear
    step(1, 2'd0, 32'h0D, 0);
    peek(2'd0, v); check("R6 w1c status", {31'd0, v[3]}, 32'd0);

    // R5: ignored match
    step(1, 2'd0, 32'h15, 0);
    step(1, 2'd3, 32'h05, 0);
    repeat (2) step(0, 2'd0, 0, 1);
    peek(2'd2, v); check("R5 counter reached compare", v, 32'd5);
    peek(2'd0, v); check("R5 status untouched", {31'd0, v[3]}, 32'd0);

    // R6: clear and match on same edge
    step(1, 2'd0, 32'h05, 0);
    step(1, 2'd3, 32'h06, 0);
    step(1, 2'd0, 32'h0D, 1);
    peek(2'd0, v); check("R6 match beats clear", {31'd0, v[3]}, 32'd1);

    // R7: counter clear beats tick, reads 0
    step(1, 2'd0, 32'h25, 1);
    peek(2'd2, v); check("R7 counter cleared", v, 32'd0);
    peek(2'd0, v); check("R7 clear bit reads 0", {31'd0, v[5]}, 32'd0);

    // R9: counter write ignored
    step(1, 2'd2, 32'hAA, 0);
    peek(2'd2, v); check("R9 counter write ignored", v, 32'd0);
    step(1, 2'd1, 32'hDEAD_BEEF, 0);
    peek(2'd1, v); check("R9 volume truncated", v, 32'h0000_BEEF);

    // R10: wrap onto compare 0
    step(1, 2'd3, 32'h00, 0);
    step(1, 2'd0, 32'h0D, 0);
    repeat ((1 << CW) - 1) step(0, 2'd0, 0, 1);
    peek(2'd0, v); check("R10 no match before wrap", {31'd0, v[3]}, 32'd0);
    step(0, 2'd0, 0, 1);
    peek(2'd2, v); check("R10 wrapped to zero", v, 32'd0);
    peek(2'd0, v); check("R10 status after wrap", {31'd0, v[3]}, 32'd1);

    // R3: independent rate bits
    step(1, 2'd0, 32'h42, 0);
    check("R3 both rates high", {30'd0, streamRateSel, dmaRateSel}, 32'd3);
    step(1, 2'd0, 32'h40, 0);
    check("R3 dma only", {30'd0, streamRateSel, dmaRateSel}, 32'd1);
    step(1, 2'd0, 32'h02, 0);
    check("R3 stream only", {30'd0, streamRateSel, dmaRateSel}, 32'd2);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      bit we, tk;
      logic [1:0] a;
      logic [31:0] d;
      we = ($urandom % 4) == 0;
      tk = ($urandom % 2) == 0;
      a  = 2'($urandom % 4);
      d  = $urandom;
      if (a == 2'd0) begin
        d[0] = ($urandom % 8) != 0;
        d[5] = ($urandom % 8) == 0;
        d[4] = ($urandom % 4) == 0;
      end
      step(we, a, d, tk);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule